// File: doc/BRIEF.md
# LMI Receive Frame Classifier

This block sits on the receive path of a frame relay link controller, between the byte-wide deframer and the receive buffer writer. It follows each incoming frame one octet per accepted cycle, extracts the 10-bit DLCI from the two address octets, and removes those two octets. Every octet after them is forwarded to the buffer writer one cycle after it arrives. The writer sees only payload, and the final payload octet is marked as last.

When the final octet of a frame arrives, the block emits a descriptor one cycle later. The descriptor carries a 3-bit frame-type code and an error flag, with the DLCI on a side output. A frame is handled as a link-management frame when three conditions hold:
- it arrives on the management channel,
- automatic management handling is enabled,
- it is long enough to contain the message-type octet.

For such a frame, the block decodes the message-type octet into a non-zero type code. In the same cycle as the descriptor, it raises a host indication carrying primitive code 13.

Clearing the automatic-handling input turns management-channel frames into ordinary transparent frames: type 000 and no indication. Buffer memory, DMA and parsing of the information elements are outside this block.

Top module: `lmi_rx_classifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pl_valid`, `pl_last`, `desc_valid` and `ind_valid` are low, and `pl_data`, `desc_word`, `desc_dlci` and `ind_prim` are zero.
- R2: The reported DLCI is built from octet bits 7:2 of the first address octet (as DLCI bits 9:4) and bits 7:4 of the second (as DLCI bits 3:0). It appears on `desc_dlci` with the descriptor, and is 0 for a one-octet frame.
- R3: Octets at frame positions 0 and 1 are never forwarded. Each octet at position 2 or later appears on `pl_data` with `pl_valid` exactly one cycle after it is accepted, in order. `pl_last` is high only with the frame's final octet, and only when that octet is at position 2 or later.
- R4: One cycle after a frame's final octet (`rx_eof`) is accepted, `desc_valid` pulses for one cycle. At that point `desc_word` holds the type code in bits 11:9 and the error flag in bit 8, with all other bits zero. While `desc_valid` is low, `desc_word`, `desc_dlci`, `ind_valid` and `ind_prim` are zero.
- R5: A management frame raises `ind_valid` with `ind_prim` = 13 in the same cycle as its descriptor. A management frame is one whose DLCI equals `MGMT_DLCI` (default 0), with `auto_lmi_en` high when its final octet is accepted, and a length of at least `MSG_POS`+1 (default 6) octets.
- R6: For a management frame, the type code comes from the octet at position `MSG_POS` (default 5): 0x7D gives 001 (status), 0x75 gives 010 (status enquiry), 0x7B gives 011 (update status), and any other value gives 111.
- R7: A frame on any other DLCI gets type 000 and no indication. Its error flag is set only if the frame is a single octet long.
- R8: A frame on the management channel whose final octet arrives while `auto_lmi_en` is low is delivered as transparent: type 000, no indication, and error flag clear when it has at least two octets.
- R9: A frame of one octet, or a management-channel frame in automatic mode that is shorter than `MSG_POS`+1 octets, gets the error flag set, type 000 and no indication. Its payload octets (positions 2 and up) are still forwarded.
- R10: `rx_sof` restarts position counting at that octet. A frame abandoned before its final octet produces no descriptor, and the next frame is classified on its own octets only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_lmi_en | input | 1 | Enables management-frame handling; sampled with the final octet |
| rx_valid | input | 1 | An octet is present on `rx_data` this cycle |
| rx_data | input | 8 | Received octet |
| rx_sof | input | 1 | Octet is the first of a frame |
| rx_eof | input | 1 | Octet is the last of a frame |
| pl_valid | output | 1 | Payload octet valid towards the buffer writer |
| pl_data | output | 8 | Payload octet |
| pl_last | output | 1 | Payload octet is the frame's last |
| desc_valid | output | 1 | Descriptor valid (one-cycle pulse) |
| desc_word | output | 16 | Descriptor word: type in 11:9, error in 8 |
| desc_dlci | output | 10 | DLCI of the completed frame |
| ind_valid | output | 1 | Host indication for a management frame |
| ind_prim | output | 4 | Indication primitive code (13) |

## Verification
The checker assumes a well-formed input stream: `rx_sof` and `rx_eof` are only raised together with `rx_valid`, every frame opens with `rx_sof`, and frame lengths stay below the saturation limit of the position counter. The bench drives octets only through a step task that always sets `rx_valid` when it sets either marker, and its frames are at most a dozen octets. It also opens each frame with a start marker, except where a frame is deliberately abandoned to exercise the restart rule. Idle gaps are inserted inside frames, so the one-cycle relation between input and payload holds across stalls rather than only in back-to-back traffic.

// File: rtl/lmi_cls_pkg.sv
package lmi_cls_pkg;

   typedef enum logic [2:0] {
      LMI_T_NONE   = 3'b000,
      LMI_T_STATUS = 3'b001,
      LMI_T_ENQ    = 3'b010,
      LMI_T_UPDATE = 3'b011,
      LMI_T_OTHER  = 3'b111
   } lmi_type_e;

   localparam logic [7:0] MT_STATUS = 8'h7D;
   localparam logic [7:0] MT_ENQ    = 8'h75;
   localparam logic [7:0] MT_UPDATE = 8'h7B;

   localparam logic [3:0] PRIM_LMI_RX = 4'd13;

   localparam int DLCI_W = 10;
   localparam int DESC_W = 16;
   localparam int TYPE_LSB = 9;
   localparam int ERR_BIT = 8;

endpackage

// File: rtl/lmi_frame_tracker.sv
module lmi_frame_tracker #(
   parameter int IDX_W   = 12,
   parameter int MSG_POS = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rx_valid,
   input  logic [7:0]                   rx_data,
   input  logic                         rx_sof,
   output logic [IDX_W-1:0]             pos,
   output logic [lmi_cls_pkg::DLCI_W-1:0] addr_dlci,
   output logic [7:0]                   msg_oct
);
   import lmi_cls_pkg::*;

   localparam logic [IDX_W-1:0] MSG_IDX  = IDX_W'(MSG_POS);
   localparam logic [IDX_W-1:0] IDX_MAX  = '1;
   localparam logic [IDX_W-1:0] IDX_ADR1 = IDX_W'(1);

   logic [IDX_W-1:0]  cnt_q;
   logic [5:0]        hi_q;
   logic [DLCI_W-1:0] dlci_q;
   logic [7:0]        msg_q;

   assign pos = rx_sof ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hi_q   <= '0;
         dlci_q <= '0;
         msg_q  <= '0;
      end else if (rx_valid) begin
         cnt_q <= (pos == IDX_MAX) ? pos : pos + 1'b1;
         if (pos == '0)
            hi_q <= rx_data[7:2];
         if (pos == IDX_ADR1)
            dlci_q <= {hi_q, rx_data[7:4]};
         if (pos == MSG_IDX)
            msg_q <= rx_data;
      end
   end

   assign addr_dlci = (pos == IDX_ADR1) ? {hi_q, rx_data[7:4]} : dlci_q;
   assign msg_oct   = (pos == MSG_IDX) ? rx_data : msg_q;

endmodule

// File: rtl/lmi_msg_decode.sv
module lmi_msg_decode (
   input  logic                   [7:0] msg_oct,
   output lmi_cls_pkg::lmi_type_e       msg_code
);
   import lmi_cls_pkg::*;

   always_comb begin
      unique case (msg_oct)
         MT_STATUS: msg_code = LMI_T_STATUS;
         MT_ENQ:    msg_code = LMI_T_ENQ;
         MT_UPDATE: msg_code = LMI_T_UPDATE;
         default:   msg_code = LMI_T_OTHER;
      endcase
   end

endmodule

// File: rtl/lmi_rx_out.sv
module lmi_rx_out #(
   parameter int IDX_W     = 12,
   parameter int MSG_POS   = 5,
   parameter int MGMT_DLCI = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           auto_lmi_en,
   input  logic                           rx_valid,
   input  logic [7:0]                     rx_data,
   input  logic                           rx_eof,
   input  logic [IDX_W-1:0]               pos,
   input  logic [lmi_cls_pkg::DLCI_W-1:0] addr_dlci,
   input  lmi_cls_pkg::lmi_type_e         msg_code,
   output logic                           pl_valid,
   output logic [7:0]                     pl_data,
   output logic                           pl_last,
   output logic                           desc_valid,
   output logic [lmi_cls_pkg::DESC_W-1:0] desc_word,
   output logic [lmi_cls_pkg::DLCI_W-1:0] desc_dlci,
   output logic                           ind_valid,
   output logic [3:0]                     ind_prim
);
   import lmi_cls_pkg::*;

   localparam logic [IDX_W-1:0]  MSG_IDX  = IDX_W'(MSG_POS);
   localparam logic [IDX_W-1:0]  BODY_IDX = IDX_W'(2);
   localparam logic [DLCI_W-1:0] MGMT_ID  = DLCI_W'(MGMT_DLCI);

   logic      body_oct;
   logic      single_oct;
   logic      on_mgmt;
   logic      lmi_short;
   logic      good_lmi;
   logic      frame_end;
   logic      err_flag;
   lmi_type_e type_code;
   logic [DESC_W-1:0] word_nxt;

   always_comb begin
      body_oct   = pos >= BODY_IDX;
      single_oct = pos == '0;
      frame_end  = rx_valid && rx_eof;
      on_mgmt    = !single_oct && (addr_dlci == MGMT_ID) && auto_lmi_en;
      lmi_short  = on_mgmt && (pos < MSG_IDX);
      good_lmi   = on_mgmt && !lmi_short;
      err_flag   = single_oct || lmi_short;
      type_code  = good_lmi ? msg_code : LMI_T_NONE;
      word_nxt   = '0;
      word_nxt[TYPE_LSB +: 3] = type_code;
      word_nxt[ERR_BIT]       = err_flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pl_valid   <= 1'b0;
         pl_data    <= '0;
         pl_last    <= 1'b0;
         desc_valid <= 1'b0;
         desc_word  <= '0;
         desc_dlci  <= '0;
         ind_valid  <= 1'b0;
         ind_prim   <= '0;
      end else begin
         pl_valid   <= rx_valid && body_oct;
         pl_data    <= (rx_valid && body_oct) ? rx_data : '0;
         pl_last    <= frame_end && body_oct;
         desc_valid <= frame_end;
         desc_word  <= frame_end ? word_nxt : '0;
         desc_dlci  <= (frame_end && !single_oct) ? addr_dlci : '0;
         ind_valid  <= frame_end && good_lmi;
         ind_prim   <= (frame_end && good_lmi) ? PRIM_LMI_RX : '0;
      end
   end

endmodule

// File: rtl/lmi_rx_classifier.sv
module lmi_rx_classifier #(
   parameter int IDX_W     = 12,
   parameter int MSG_POS   = 5,
   parameter int MGMT_DLCI = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        auto_lmi_en,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   input  logic        rx_sof,
   input  logic        rx_eof,
   output logic        pl_valid,
   output logic [7:0]  pl_data,
   output logic        pl_last,
   output logic        desc_valid,
   output logic [15:0] desc_word,
   output logic [9:0]  desc_dlci,
   output logic        ind_valid,
   output logic [3:0]  ind_prim
);
   import lmi_cls_pkg::*;

   generate
      if (MSG_POS < 2)
         $error("message-type octet must follow the two address octets");
      if (IDX_W < 3 || MSG_POS >= (1 << IDX_W) - 1)
         $error("position counter too narrow for the message-type offset");
      if (MGMT_DLCI < 0 || MGMT_DLCI >= (1 << DLCI_W))
         $error("management DLCI out of the 10-bit range");
   endgenerate

   logic [IDX_W-1:0]  pos;
   logic [DLCI_W-1:0] addr_dlci;
   logic [7:0]        msg_oct;
   lmi_type_e         msg_code;

   lmi_frame_tracker #(
      .IDX_W   (IDX_W),
      .MSG_POS (MSG_POS)
   ) trk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_sof    (rx_sof),
      .pos       (pos),
      .addr_dlci (addr_dlci),
      .msg_oct   (msg_oct)
   );

   lmi_msg_decode dec_i (
      .msg_oct  (msg_oct),
      .msg_code (msg_code)
   );

   lmi_rx_out #(
      .IDX_W     (IDX_W),
      .MSG_POS   (MSG_POS),
      .MGMT_DLCI (MGMT_DLCI)
   ) out_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_lmi_en (auto_lmi_en),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .rx_eof      (rx_eof),
      .pos         (pos),
      .addr_dlci   (addr_dlci),
      .msg_code    (msg_code),
      .pl_valid    (pl_valid),
      .pl_data     (pl_data),
      .pl_last     (pl_last),
      .desc_valid  (desc_valid),
      .desc_word   (desc_word),
      .desc_dlci   (desc_dlci),
      .ind_valid   (ind_valid),
      .ind_prim    (ind_prim)
   );

endmodule

// File: rtl/lmi_rx_classifier_chk.sv
module lmi_rx_classifier_chk #(
   parameter int MGMT_DLCI = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        auto_lmi_en,
   input logic        rx_valid,
   input logic [7:0]  rx_data,
   input logic        rx_eof,
   input logic        pl_valid,
   input logic [7:0]  pl_data,
   input logic        pl_last,
   input logic        desc_valid,
   input logic [15:0] desc_word,
   input logic [9:0]  desc_dlci,
   input logic        ind_valid,
   input logic [3:0]  ind_prim
);

   AST_PL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      pl_valid |-> ($past(rx_valid) && pl_data == $past(rx_data))); // R3

   AST_LAST_WITH_DESC: assert property (@(posedge clk) disable iff (!rst_n)
      pl_last |-> (pl_valid && desc_valid)); // R3

   AST_DESC_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> $past(rx_valid && rx_eof)); // R4

   AST_DESC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |=> !desc_valid || $past(rx_valid && rx_eof)); // R4

   AST_QUIET_WITHOUT_DESC: assert property (@(posedge clk) disable iff (!rst_n)
      !desc_valid |-> (desc_word == 16'h0 && desc_dlci == 10'h0 && !ind_valid && ind_prim == 4'h0)); // R4

   AST_IND_PRIM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ind_valid |-> (ind_prim == 4'd13 && desc_valid)); // R5

   AST_IND_TYPED: assert property (@(posedge clk) disable iff (!rst_n)
      ind_valid |-> (desc_word[11:9] != 3'b000 && !desc_word[8])); // R6

   AST_PLAIN_UNTYPED: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !ind_valid) |-> desc_word[11:9] == 3'b000); // R7

   AST_OTHER_DLCI_NO_IND: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_dlci != 10'(MGMT_DLCI)) |-> !ind_valid); // R7

   AST_MODE_OFF_NO_IND: assert property (@(posedge clk) disable iff (!rst_n)
      ind_valid |-> $past(auto_lmi_en)); // R8

   AST_ERR_NO_IND: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_word[8]) |-> !ind_valid); // R9

endmodule

bind lmi_rx_classifier lmi_rx_classifier_chk #(.MGMT_DLCI(MGMT_DLCI)) chk_i (.*);

// File: tb/lmi_rx_classifier_tb_top.sv
module lmi_rx_classifier_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        auto_lmi_en = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_sof = 1'b0;
   logic        rx_eof = 1'b0;
   logic        pl_valid;
   logic [7:0]  pl_data;
   logic        pl_last;
   logic        desc_valid;
   logic [15:0] desc_word;
   logic [9:0]  desc_dlci;
   logic        ind_valid;
   logic [3:0]  ind_prim;

   always #5 clk = ~clk;

   lmi_rx_classifier dut_i (
      .clk(clk), .rst_n(rst_n), .auto_lmi_en(auto_lmi_en),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
      .desc_valid(desc_valid), .desc_word(desc_word), .desc_dlci(desc_dlci),
      .ind_valid(ind_valid), .ind_prim(ind_prim)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   string scen = "";

   logic [7:0] frm[$];
   logic [7:0] fbuf[$];

   logic        e_pl_valid, e_pl_last, e_desc_valid, e_ind_valid;
   logic [7:0]  e_pl_data;
   logic [15:0] e_desc_word;
   logic [9:0]  e_desc_dlci;
   logic [3:0]  e_ind_prim;
   string       word_tag;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] %s: actual=%0h expected=%0h", tag, scen, what, act, exp);
      end
   endtask

   // Behavioural reference: expected outputs after the coming edge.
   task automatic model(input bit v, input logic [7:0] d, input bit s, input bit e);
      int n;
      int p;
      bit mgmt;
      bit shrt;
      logic [2:0] ty;
      bit err;
      e_pl_valid = 0; e_pl_data = 0; e_pl_last = 0;
      e_desc_valid = 0; e_desc_word = 0; e_desc_dlci = 0;
      e_ind_valid = 0; e_ind_prim = 0; word_tag = "R4";
      if (v) begin
         if (s) frm.delete();
         frm.push_back(d);
         n = frm.size();
         p = n - 1;
         if (p >= 2) begin
            e_pl_valid = 1; e_pl_data = d; e_pl_last = e;
         end
         if (e) begin
            e_desc_valid = 1;
            e_desc_dlci = (n >= 2) ? {frm[0][7:2], frm[1][7:4]} : 10'h0;
            mgmt = (n >= 2) && (e_desc_dlci == 10'h0) && auto_lmi_en;
            shrt = n < 6;
            err  = (n < 2) || (mgmt && shrt);
            ty   = 3'b000;
            if (mgmt && !shrt) begin
               case (frm[5])
                  8'h7D:   ty = 3'b001;
                  8'h75:   ty = 3'b010;
                  8'h7B:   ty = 3'b011;
                  default: ty = 3'b111;
               endcase
               e_ind_valid = 1;
               e_ind_prim = 4'd13;
               word_tag = "R6";
            end else if (err) word_tag = "R9";
            else if (e_desc_dlci == 10'h0 && !auto_lmi_en) word_tag = "R8";
            else word_tag = "R7";
            e_desc_word = {4'h0, ty, err, 8'h00};
         end
      end
   endtask

   task automatic compare();
      chk(pl_valid == e_pl_valid, "R3", "pl_valid", pl_valid, e_pl_valid);
      chk(pl_data == e_pl_data, "R3", "pl_data", pl_data, e_pl_data);
      chk(pl_last == e_pl_last, "R3", "pl_last", pl_last, e_pl_last);
      chk(desc_valid == e_desc_valid, "R4", "desc_valid", desc_valid, e_desc_valid);
      chk(desc_word == e_desc_word, word_tag, "desc_word", desc_word, e_desc_word);
      chk(desc_dlci == e_desc_dlci, "R2", "desc_dlci", desc_dlci, e_desc_dlci);
      chk(ind_valid == e_ind_valid, "R5", "ind_valid", ind_valid, e_ind_valid);
      chk(ind_prim == e_ind_prim, "R5", "ind_prim", ind_prim, e_ind_prim);
   endtask

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic step(input bit v, input logic [7:0] d, input bit s, input bit e);
      rx_valid = v; rx_data = v ? d : 8'h00; rx_sof = v && s; rx_eof = v && e;
      model(v, d, s, e);
      @(negedge clk);
      compare();
   endtask

   task automatic send_frame(input bit gaps);
      for (int i = 0; i < fbuf.size(); i++) begin
         step(1'b1, fbuf[i], i == 0, i == fbuf.size() - 1);
         if (gaps && (i % 2 == 1)) step(1'b0, 8'h00, 1'b0, 1'b0);
      end
      step(1'b0, 8'h00, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      scen = "reset";
      // R1: outputs quiet during reset
      chk({pl_valid, pl_last, desc_valid, ind_valid} == 4'b0, "R1", "valids in reset",
          {pl_valid, pl_last, desc_valid, ind_valid}, 0);
      chk(desc_word == 0 && desc_dlci == 0 && ind_prim == 0 && pl_data == 0, "R1",
          "data in reset", desc_word, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: first cycle after reset
      chk({pl_valid, desc_valid, ind_valid} == 3'b0, "R1", "after reset",
          {pl_valid, desc_valid, ind_valid}, 0);

      scen = "status R5 R6";
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00, 8'h7D, 8'h01, 8'h01, 8'h02};
      send_frame(1'b0);
      scen = "enquiry with gaps R6";
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00, 8'h75, 8'h01, 8'h03};
      send_frame(1'b1);
      scen = "update R6";
      fbuf = '{8'h01, 8'h0B, 8'h03, 8'h09, 8'h00, 8'h7B, 8'h57, 8'h03, 8'h01, 8'h02};
      send_frame(1'b0);
      scen = "unknown type R6";
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00, 8'h55, 8'hAA};
      send_frame(1'b0);
      scen = "exact length R5";
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00, 8'h7D};
      send_frame(1'b0);
      scen = "other dlci R7 R2";
      fbuf = '{8'h18, 8'h41, 8'h03, 8'h09, 8'h00, 8'h7D, 8'h11};
      send_frame(1'b1);
      scen = "dlci 1023 R2";
      fbuf = '{8'hFC, 8'hF1, 8'hDE, 8'hAD};
      send_frame(1'b0);
      scen = "short other dlci R7";
      fbuf = '{8'h40, 8'h01, 8'h99};
      send_frame(1'b0);
      scen = "auto off R8";
      auto_lmi_en = 1'b0;
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00, 8'h7D, 8'h01};
      send_frame(1'b0);
      fbuf = '{8'h00, 8'h01, 8'h03};
      send_frame(1'b0);
      auto_lmi_en = 1'b1;
      scen = "short lmi R9";
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09};
      send_frame(1'b0);
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00};
      send_frame(1'b1);
      scen = "two octets R9";
      fbuf = '{8'h00, 8'h01};
      send_frame(1'b0);
      scen = "one octet R9";
      fbuf = '{8'h00};
      send_frame(1'b0);
      scen = "restart R10";
      step(1'b1, 8'h18, 1'b1, 1'b0);
      step(1'b1, 8'h41, 1'b0, 1'b0);
      step(1'b1, 8'h77, 1'b0, 1'b0);
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00, 8'h75};
      send_frame(1'b0);
      scen = "back to back R4";
      fbuf = '{8'h00, 8'h01, 8'h03, 8'h09, 8'h00, 8'h7B, 8'h44};
      for (int i = 0; i < fbuf.size(); i++)
         step(1'b1, fbuf[i], i == 0, i == fbuf.size() - 1);
      fbuf = '{8'h10, 8'h21, 8'h03, 8'h09, 8'h00, 8'h7D};
      send_frame(1'b0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule